// File: doc/BRIEF.md
# Row-Buffered Dynamic Memory Array

This block is a cycle-level, synthesizable model of a dynamic memory device. It has one multiplexed address port and a single row buffer. Pulling the active-low row strobe low while the device is idle takes the address pins as a row number. The whole row then moves from the array into the buffer. While the row stays open, the same pins select a column, and separate read and write controls access single words in the buffer, much as with a static RAM. Raising the strobe copies the buffer back into its row.

Moving a row into the buffer destroys the array copy, which is overwritten with the poison byte 8'hA5. Every close therefore writes the row back, whether or not it was modified. Opening a row and recovering after a close both take a fixed number of cycles, while buffer accesses take one cycle. The ready output is low during the open and recovery intervals. A request the device cannot take is dropped and reported on the error output for one cycle.

Top module: `rowbuf_dram`

## Requirements
- R1: While and after reset, ready_o is 1, err_o is 0, rdata_o is 0, and every location of every row reads 0 once opened.
- R2: When row_strobe_ni is sampled low in the idle state, addr_i[3:0] is taken as the row number and that row is loaded into the buffer. ready_o is 0 for the three cycles after that edge and returns to 1 after the third.
- R3: While a row is open and row_strobe_ni is low, a cycle with col_rd_i high puts the buffer word at column addr_i[3:0] on rdata_o after that edge. A cycle with col_wr_i high stores wdata_i at that column. When both are high in one cycle, rdata_o returns the word held before the write.
- R4: When row_strobe_ni is sampled high with a row open, the buffer is written back to the open row. ready_o is then 0 for three cycles and returns to 1 after the third.
- R5: Opening a row fills the array copy of that row with 8'hA5. Because every close writes the row back, a row that is opened and closed with no writes still holds its earlier data when reopened.
- R6: A low row_strobe_ni sampled during recovery opens no row and sets err_o to 1 for the following cycle. Once recovery ends with the strobe high, the device is idle with ready_o at 1, and rows that were not opened keep their data.
- R7: A column read or write issued while no row is open, while ready_o is 0, or while the strobe is high is ignored. Neither the buffer nor rdata_o changes, and err_o is 1 for the following cycle only.
- R8: rdata_o holds its last value in cycles with no accepted read.
- R9: Writes to one row leave all other rows unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_strobe_ni | input | 1 | Row strobe, active low: a low level opens a row, a high level closes it |
| addr_i | input | 4 | Shared address: the row when opening, the column when accessing |
| col_rd_i | input | 1 | Column read request |
| col_wr_i | input | 1 | Column write request |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| ready_o | output | 1 | Low during the row-open and recovery intervals |
| err_o | output | 1 | One-cycle pulse after an ignored request |

## Verification
The assertions assume the strobe and column controls are valid from the first edge after reset. They also assume a load and a write-back never fall in the same cycle, which holds because the sequencer opens rows only when idle and closes them only when open. The bench changes every input at the falling edge and holds it through the next rising edge. Illegal requests (a strobe during recovery, column accesses during opening or while idle) are issued on purpose and only on chosen cycles, so each illegal request maps to one expected error pulse. A sweep opens every row three times and touches every column.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPENING,
    ST_OPEN,
    ST_RECOVER
  } rb_state_e;
endpackage

// File: rtl/rb_seq.sv
module rb_seq
  import rb_pkg::*;
#(
  parameter int OPEN_LAT = 3,
  parameter int REC_LAT  = 3,
  parameter int RAW      = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           strobe_ni,
  input  logic           col_rd_i,
  input  logic           col_wr_i,
  input  logic [RAW-1:0] row_addr_i,
  output logic           load_o,
  output logic           wb_o,
  output logic           acc_ok_o,
  output logic           ready_o,
  output logic           err_o,
  output logic [RAW-1:0] row_o
);
  localparam int LMAX = (OPEN_LAT > REC_LAT) ? OPEN_LAT : REC_LAT;
  localparam int CW   = (LMAX > 1) ? $clog2(LMAX) : 1;

  rb_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           err_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    load_o = 1'b0;
    wb_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (!strobe_ni) begin
        load_o = 1'b1;
        st_d   = ST_OPENING;
        cnt_d  = CW'(OPEN_LAT - 1);
      end
      ST_OPENING: if (cnt_q == '0) st_d = ST_OPEN;
                  else cnt_d = cnt_q - 1'b1;
      ST_OPEN: if (strobe_ni) begin
        wb_o  = 1'b1;
        st_d  = ST_RECOVER;
        cnt_d = CW'(REC_LAT - 1);
      end
      ST_RECOVER: if (cnt_q == '0) st_d = ST_IDLE;
                  else cnt_d = cnt_q - 1'b1;
      default: st_d = ST_IDLE;
    endcase
  end

  assign acc_ok_o = (st_q == ST_OPEN) && !strobe_ni;
  assign ready_o  = (st_q == ST_IDLE) || (st_q == ST_OPEN);
  // dropped column access, or strobe asserted while recovering
  assign err_d    = ((col_rd_i || col_wr_i) && !acc_ok_o) ||
                    ((st_q == ST_RECOVER) && !strobe_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      err_o <= 1'b0;
      row_o <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      err_o <= err_d;
      if (load_o) row_o <= row_addr_i;
    end
  end

  // R2
  open_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !ready_o);
  // R4
  close_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |=> !ready_o);
  // R7
  busy_access_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((col_rd_i || col_wr_i) && !ready_o) |=> err_o);
  // R6
  recover_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_o && !load_o) |=> !load_o);
endmodule

// File: rtl/rb_array.sv
module rb_array #(
  parameter int          ROWS   = 16,
  parameter int          COLS   = 16,
  parameter int          DW     = 8,
  parameter int          RAW    = 4,
  parameter logic [DW-1:0] POISON = 8'hA5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [RAW-1:0]       load_row_i,
  output logic [COLS*DW-1:0]   rd_data_o,
  input  logic                 wb_i,
  input  logic [RAW-1:0]       wb_row_i,
  input  logic [COLS*DW-1:0]   wb_data_i
);
  localparam int RW = COLS * DW;

  logic [RW-1:0] rows_w [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [RW-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                row_q <= '0;
      else if (wb_i && wb_row_i == RAW'(r))       row_q <= wb_data_i;
      else if (load_i && load_row_i == RAW'(r))   row_q <= {COLS{POISON}};
    end
    assign rows_w[r] = row_q;
  end

  assign rd_data_o = rows_w[load_row_i];

  // R5
  single_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && wb_i));
  // R5
  poison_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rows_w[$past(load_row_i)] == {COLS{POISON}}));
endmodule

// File: rtl/rb_rowbuf.sv
module rb_rowbuf #(
  parameter int COLS = 16,
  parameter int DW   = 8,
  parameter int CAW  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [COLS*DW-1:0] load_row_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [CAW-1:0]     col_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [COLS*DW-1:0] row_o
);
  logic [DW-1:0] cell_q [COLS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < COLS; c++) cell_q[c] <= '0;
      rdata_o <= '0;
    end else begin
      for (int c = 0; c < COLS; c++) begin
        if (load_i)                           cell_q[c] <= load_row_i[c*DW +: DW];
        else if (wr_i && col_i == CAW'(c))    cell_q[c] <= wdata_i;
      end
      if (rd_i) rdata_o <= cell_q[col_i];
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_flat
    assign row_o[c*DW +: DW] = cell_q[c];
  end

  // R3
  load_vs_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && (rd_i || wr_i)));
  // R9
  buf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i || wr_i) |=> $stable(row_o));
  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/rowbuf_dram.sv
module rowbuf_dram
  import rb_pkg::*;
#(
  parameter int            ROWS     = 16,
  parameter int            COLS     = 16,
  parameter int            DW       = 8,
  parameter int            OPEN_LAT = 3,
  parameter int            REC_LAT  = 3,
  parameter logic [DW-1:0] POISON   = 8'hA5,
  localparam int           RAW      = $clog2(ROWS),
  localparam int           CAW      = $clog2(COLS),
  localparam int           AW       = (RAW > CAW) ? RAW : CAW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          row_strobe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          col_rd_i,
  input  logic          col_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o,
  output logic          err_o
);
  logic               load_w, wb_w, acc_ok_w;
  logic [RAW-1:0]     row_w;
  logic [COLS*DW-1:0] arr_rd_w, buf_row_w;

  rb_seq #(.OPEN_LAT(OPEN_LAT), .REC_LAT(REC_LAT), .RAW(RAW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_ni  (row_strobe_ni),
    .col_rd_i   (col_rd_i),
    .col_wr_i   (col_wr_i),
    .row_addr_i (addr_i[RAW-1:0]),
    .load_o     (load_w),
    .wb_o       (wb_w),
    .acc_ok_o   (acc_ok_w),
    .ready_o    (ready_o),
    .err_o      (err_o),
    .row_o      (row_w)
  );

  rb_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .RAW(RAW), .POISON(POISON)) u_arr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_w),
    .load_row_i (addr_i[RAW-1:0]),
    .rd_data_o  (arr_rd_w),
    .wb_i       (wb_w),
    .wb_row_i   (row_w),
    .wb_data_i  (buf_row_w)
  );

  rb_rowbuf #(.COLS(COLS), .DW(DW), .CAW(CAW)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_w),
    .load_row_i (arr_rd_w),
    .rd_i       (col_rd_i && acc_ok_w),
    .wr_i       (col_wr_i && acc_ok_w),
    .col_i      (addr_i[CAW-1:0]),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .row_o      (buf_row_w)
  );
endmodule

// File: tb/sim_rowbuf_dram.sv
module sim_rowbuf_dram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe_n = 1'b1;
  logic [3:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ready, err;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  rowbuf_dram u0 (
    .clk_i(clk), .rst_ni(rst_n), .row_strobe_ni(strobe_n), .addr_i(addr),
    .col_rd_i(rd), .col_wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .ready_o(ready), .err_o(err)
  );

  function automatic logic [7:0] pat(int r, int c);
    return 8'((r * 37 + c * 11 + 8'h5A) & 8'hFF);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic open_row(int r);
    strobe_n = 1'b0; addr = 4'(r);
    step();
    for (int i = 0; i < 3; i++) begin
      chk("R2 ready during open", int'(ready), 0);
      step();
    end
    chk("R2 ready after open", int'(ready), 1);
  endtask

  task automatic close_row();
    strobe_n = 1'b1;
    step();
    for (int i = 0; i < 3; i++) begin
      chk("R4 ready during recovery", int'(ready), 0);
      step();
    end
    chk("R4 ready after recovery", int'(ready), 1);
  endtask

  task automatic rd_col(int c, int exp, string req);
    rd = 1'b1; addr = 4'(c);
    step();
    rd = 1'b0;
    chk(req, int'(rdata), exp);
  endtask

  task automatic wr_col(int c, int d);
    wr = 1'b1; addr = 4'(c); wdata = 8'(d);
    step();
    wr = 1'b0;
  endtask

  initial begin
    #(10 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    @(negedge clk); @(negedge clk);
    chk("R1 ready in reset", int'(ready), 1);
    chk("R1 err in reset", int'(err), 0);
    chk("R1 rdata in reset", int'(rdata), 0);
    rst_n = 1'b1;
    step();

    // R1, R9: zero after reset, fill every row
    for (int r = 0; r < 16; r++) begin
      open_row(r);
      for (int c = 0; c < 16; c++) rd_col(c, 0, "R1 zero after reset");
      for (int c = 0; c < 16; c++) wr_col(c, pat(r, c));
      close_row();
    end
    // R3, R9: read back, no writes
    for (int r = 0; r < 16; r++) begin
      open_row(r);
      for (int c = 0; c < 16; c++) rd_col(c, pat(r, c), "R3 readback");
      chk("R3 no err on legal access", int'(err), 0);
      close_row();
    end
    // R5: unmodified rows survive via write-back
    for (int r = 0; r < 16; r++) begin
      open_row(r);
      for (int c = 0; c < 16; c++) rd_col(c, pat(r, c), "R5 unmodified writeback");
      close_row();
    end

    // R3: read and write together, R8: hold
    open_row(2);
    rd = 1'b1; wr = 1'b1; addr = 4'd5; wdata = 8'hC3;
    step();
    rd = 1'b0; wr = 1'b0;
    chk("R3 read with write gives old", int'(rdata), int'(pat(2, 5)));
    rd_col(5, 8'hC3, "R3 write landed");
    step(); step();
    chk("R8 rdata hold", int'(rdata), 8'hC3);

    // R6: strobe during recovery
    strobe_n = 1'b1;
    step();
    strobe_n = 1'b0; addr = 4'd7;
    step();
    chk("R6 err on strobe in recovery", int'(err), 1);
    strobe_n = 1'b1;
    step();
    chk("R6 err one cycle", int'(err), 0);
    step();
    chk("R6 idle after recovery", int'(ready), 1);
    step();
    chk("R6 no row opened", int'(ready), 1);

    // R7: column read while idle
    prev = rdata;
    rd = 1'b1; addr = 4'd3;
    step();
    rd = 1'b0;
    chk("R7 err on idle read", int'(err), 1);
    chk("R7 rdata unchanged", int'(rdata), int'(prev));
    step();
    chk("R7 err one cycle", int'(err), 0);

    // R7: write during opening is dropped
    strobe_n = 1'b0; addr = 4'd4;
    step();
    wr = 1'b1; addr = 4'd0; wdata = 8'hFF;
    step();
    wr = 1'b0;
    chk("R7 err on busy write", int'(err), 1);
    step(); step();
    chk("R7 open completes", int'(ready), 1);
    rd_col(0, pat(4, 0), "R7 busy write ignored");
    close_row();

    // R6, R9: other rows intact
    open_row(7);
    for (int c = 0; c < 16; c++) rd_col(c, pat(7, c), "R6 row 7 intact");
    close_row();
    open_row(2);
    rd_col(5, 8'hC3, "R9 row 2 col 5");
    rd_col(4, pat(2, 4), "R9 row 2 col 4");
    close_row();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule